// File: doc/BRIEF.md
# UART Register Front-End

This block is the byte-wide register window of a classic PC-style serial port, as a CPU sees it through memory-mapped loads and stores. A 3-bit offset selects one of eight byte locations. Several locations are shared between logical registers. Which register an access reaches depends on the access direction and on the divisor-latch access bit held in bit 7 of the line control register.

The block holds the line control register, the interrupt enable register and the 16-bit baud divisor. It latches each byte delivered by the receiver, reports data-ready and transmit-holding-empty in the line status register, and raises a receive interrupt. A CPU write to the transmit holding register is passed to the transmitter as a byte and a one-cycle load strobe. The serial shifting engine connects to the receive, transmit, divisor and frame-configuration pins. This block does no serial shifting and has no modem control lines.

Top module: `uart_regfile`

## Requirements
- R1: After reset, offset 3 (line control) reads 0x00, offset 1 (interrupt enable) reads 0x00, offset 5 (line status) reads 0x20, offset 2 (interrupt status) reads 0x01, irq and tx_load are 0, and baud_div equals DIV_RST (default 0).
- R2: Offset 3 stores all 8 written bits and reads them back. frame_cfg always shows this register. Its bit 7 is the divisor-latch access bit (DLAB).
- R3: While DLAB is 1, offset 0 accesses the divisor low byte and offset 1 the divisor high byte. baud_div equals {high, low}. These accesses leave the transmit path and the interrupt enable register untouched.
- R4: While DLAB is 0, offset 1 stores bits 3:0 of the written byte. Bits 7:4 always read as 0.
- R5: A cycle with rx_valid high stores rx_byte. From the next cycle, line status bit 0 (data ready) reads 1. A read of offset 0 with DLAB 0 returns the stored byte.
- R6: A read of offset 0 with DLAB 0 clears data ready after that cycle. If rx_valid is high in the same cycle, data ready stays 1 and the new byte is stored. A read of offset 0 with DLAB 1 leaves data ready unchanged.
- R7: irq is high exactly when interrupt enable bit 0 and data ready are both 1. Offset 2 reads 0x04 while irq is high and 0x01 otherwise.
- R8: A write to offset 0 with DLAB 0 puts the byte on tx_byte and raises tx_load for exactly the next cycle. It also clears line status bit 5 (transmit holding empty). tx_taken sets bit 5 again, but a write in the same cycle takes precedence.
- R9: Offsets 4, 6 and 7 read 0x00. Writes to offsets 2, 4, 5, 6 and 7 change no readable register and raise no tx_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| rx_valid | input | 1 | Receiver delivers a byte this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_load | output | 1 | One-cycle pulse: new byte on tx_byte |
| tx_taken | input | 1 | Transmitter has taken the holding byte |
| baud_div | output | 16 | Baud divisor {high, low} |
| frame_cfg | output | 8 | Line control register contents |
| irq | output | 1 | Receive-data interrupt |

## Verification
The hardest situations to reach are the collisions at a single clock edge: a data read that coincides with a new received byte, and a transmit write that coincides with the transmitter's take signal. The bench drives both strobes in the same cycle and then reads the status back. A second hard case is the divisor-latch alias. To reach it, the bench sets DLAB, reads and writes offsets 0 and 1, and then clears DLAB. It confirms that data ready, the interrupt enable contents and the transmit strobe were left alone, while baud_div follows the divisor writes.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ISTA = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;

  localparam int LSTA_DR_BIT   = 0;
  localparam int LSTA_THRE_BIT = 5;
  localparam int DLAB_BIT      = 7;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_RBR, SEL_DLO, SEL_IEN, SEL_DHI, SEL_ISTA, SEL_LCTL, SEL_LSTA
  } rd_sel_t;

  typedef struct packed {
    logic wr_thr;
    logic wr_ien;
    logic wr_lctl;
    logic wr_dlo;
    logic wr_dhi;
    logic rd_rbr;
  } bus_strobe_t;

  function automatic logic [BYTE_W-1:0] lsta_pack(input logic dr, input logic thre);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[LSTA_DR_BIT]   = dr;
    v[LSTA_THRE_BIT] = thre;
    return v;
  endfunction

  function automatic logic [BYTE_W-1:0] ista_code(input logic pend);
    return pend ? 8'h04 : 8'h01;
  endfunction
endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
  import uart_reg_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dlab,
  output bus_strobe_t       stb,
  output rd_sel_t           rsel
);
  logic do_wr, do_rd;
  assign do_wr = sel & wr;
  assign do_rd = sel & ~wr;

  always_comb begin
    stb  = '0;
    rsel = SEL_ZERO;
    case (addr)
      OFS_DATA: begin
        if (dlab) begin
          rsel       = SEL_DLO;
          stb.wr_dlo = do_wr;
        end else begin
          rsel       = SEL_RBR;
          stb.wr_thr = do_wr;
          stb.rd_rbr = do_rd;
        end
      end
      OFS_IEN: begin
        if (dlab) begin
          rsel       = SEL_DHI;
          stb.wr_dhi = do_wr;
        end else begin
          rsel       = SEL_IEN;
          stb.wr_ien = do_wr;
        end
      end
      OFS_ISTA: rsel = SEL_ISTA;
      OFS_LCTL: begin
        rsel        = SEL_LCTL;
        stb.wr_lctl = do_wr;
      end
      OFS_LSTA: rsel = SEL_LSTA;
      default:  rsel = SEL_ZERO;
    endcase
  end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         rd_clear,
  output logic [W-1:0] rx_data,
  output logic         dr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      dr      <= 1'b0;
    end else if (rx_valid) begin
      rx_data <= rx_byte;
      dr      <= 1'b1;
    end else if (rd_clear) begin
      dr      <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_holding.sv
module uart_tx_holding #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         taken,
  output logic [W-1:0] tx_byte,
  output logic         tx_load,
  output logic         thre
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_byte <= '0;
      tx_load <= 1'b0;
      thre    <= 1'b1;
    end else begin
      tx_load <= wr;
      if (wr) begin
        tx_byte <= wdata;
        thre    <= 1'b0;
      end else if (taken) begin
        thre    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
#(
  parameter int                IEN_BITS = 4,
  parameter logic [2*BYTE_W-1:0] DIV_RST  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic [BYTE_W-1:0]   tx_byte,
  output logic                tx_load,
  input  logic                tx_taken,
  output logic [2*BYTE_W-1:0] baud_div,
  output logic [BYTE_W-1:0]   frame_cfg,
  output logic                irq
);
  localparam int IEN_PAD = BYTE_W - IEN_BITS;

  logic [BYTE_W-1:0]   lctl_q;
  logic [IEN_BITS-1:0] ien_q;
  logic [BYTE_W-1:0]   dlo_q, dhi_q;
  logic [BYTE_W-1:0]   rx_data;
  logic                dr_q, thre_q;
  logic                dlab;
  bus_strobe_t         stb;
  rd_sel_t             rsel;

  // named internal events, used by the checker
  logic thr_write, rbr_read;
  assign thr_write = stb.wr_thr;
  assign rbr_read  = stb.rd_rbr;

  assign dlab = lctl_q[DLAB_BIT];

  uart_addr_decode u_dec (
    .sel (bus_sel),
    .wr  (bus_wr),
    .addr(bus_addr),
    .dlab(dlab),
    .stb (stb),
    .rsel(rsel)
  );

  uart_rx_holding #(.W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .rd_clear(rbr_read),
    .rx_data (rx_data),
    .dr      (dr_q)
  );

  uart_tx_holding #(.W(BYTE_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (thr_write),
    .wdata  (bus_wdata),
    .taken  (tx_taken),
    .tx_byte(tx_byte),
    .tx_load(tx_load),
    .thre   (thre_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl_q <= '0;
      ien_q  <= '0;
      dlo_q  <= DIV_RST[BYTE_W-1:0];
      dhi_q  <= DIV_RST[2*BYTE_W-1:BYTE_W];
    end else begin
      if (stb.wr_lctl) lctl_q <= bus_wdata;
      if (stb.wr_ien)  ien_q  <= bus_wdata[IEN_BITS-1:0];
      if (stb.wr_dlo)  dlo_q  <= bus_wdata;
      if (stb.wr_dhi)  dhi_q  <= bus_wdata;
    end
  end

  assign irq       = ien_q[0] & dr_q;
  assign baud_div  = {dhi_q, dlo_q};
  assign frame_cfg = lctl_q;

  always_comb begin
    unique case (rsel)
      SEL_RBR:  bus_rdata = rx_data;
      SEL_DLO:  bus_rdata = dlo_q;
      SEL_IEN:  bus_rdata = {{IEN_PAD{1'b0}}, ien_q};
      SEL_DHI:  bus_rdata = dhi_q;
      SEL_ISTA: bus_rdata = ista_code(irq);
      SEL_LCTL: bus_rdata = lctl_q;
      SEL_LSTA: bus_rdata = lsta_pack(dr_q, thre_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic clk,
  input logic rst_n,
  input logic thr_write,
  input logic rbr_read,
  input logic rx_valid,
  input logic tx_taken,
  input logic tx_load,
  input logic thre,
  input logic dr,
  input logic irq
);
  // R8
  thre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !thre);
  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(thr_write));
  // R8
  thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_taken && !thr_write) |=> thre);
  // R5
  dr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> dr);
  // R6
  dr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_read && !rx_valid) |=> !dr);
  // R7
  irq_needs_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dr);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .thr_write(thr_write),
  .rbr_read (rbr_read),
  .rx_valid (rx_valid),
  .tx_taken (tx_taken),
  .tx_load  (tx_load),
  .thre     (thre_q),
  .dr       (dr_q),
  .irq      (irq)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0, tx_byte;
  logic        tx_load, tx_taken = 1'b0, irq;
  logic [15:0] baud_div;
  logic [7:0]  frame_cfg;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .tx_load(tx_load), .tx_taken(tx_taken), .baud_div(baud_div),
    .frame_cfg(frame_cfg), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  function automatic logic [7:0] lsta(input logic dr, input logic thre);
    return (dr ? 8'h01 : 8'h00) | (thre ? 8'h20 : 8'h00);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd3, d); chk("R1 lctl", d, 8'h00);
    rd(3'd1, d); chk("R1 ien", d, 8'h00);
    rd(3'd5, d); chk("R1 lsta", d, 8'h20);
    rd(3'd2, d); chk("R1 ista", d, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 tx_load", tx_load, 0);
    chk("R1 baud_div", baud_div, 16'h0000);

    // R2 full sweep of line control
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, v[7:0]);
      rd(3'd3, d);
      chk("R2 readback", d, v[7:0]);
      chk("R2 frame_cfg", frame_cfg, v[7:0]);
    end
    wr(3'd3, 8'h00);

    // R4 interrupt enable sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, v[7:0]);
      rd(3'd1, d);
      chk("R4 ien mask", d, v[7:0] & 8'h0F);
    end
    wr(3'd1, 8'h0A);

    // R3 divisor alias
    for (int i = 0; i < 16; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(i * 17 + 1); hi = ~lo;
      wr(3'd3, 8'h83);
      wr(3'd0, lo);
      chk("R3 no tx_load on divisor write", tx_load, 0);
      wr(3'd1, hi);
      rd(3'd0, d); chk("R3 dlo", d, lo);
      rd(3'd1, d); chk("R3 dhi", d, hi);
      chk("R3 baud_div", baud_div, {hi, lo});
      wr(3'd3, 8'h03);
      rd(3'd1, d); chk("R3 ien kept", d, 8'h0A);
      rd(3'd5, d); chk("R3 thre kept", d, 8'h20);
    end
    wr(3'd3, 8'h00);

    // R5 R7 R6 receive path, enable toggled
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b; logic en;
      b = 8'(i * 8 + 3); en = i[0];
      wr(3'd1, {7'd0, en});
      rx(b);
      rd(3'd5, d); chk("R5 dr set", d, lsta(1, 1));
      chk("R7 irq", irq, en);
      rd(3'd2, d); chk("R7 ista", d, en ? 8'h04 : 8'h01);
      rd(3'd0, d); chk("R5 rx data", d, b);
      rd(3'd5, d); chk("R6 dr clear", d, lsta(0, 1));
      chk("R7 irq off", irq, 0);
    end

    // R6 read with DLAB=1 leaves data ready
    wr(3'd1, 8'h01);
    rx(8'h5C);
    wr(3'd3, 8'h80);
    rd(3'd0, d);
    wr(3'd3, 8'h00);
    rd(3'd5, d); chk("R6 dlab read keeps dr", d, lsta(1, 1));
    chk("R7 irq kept", irq, 1);
    // R6 collision: read and new byte at once
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'd0; rx_valid = 1; rx_byte = 8'hC3;
    #1 chk("R6 collision old byte", bus_rdata, 8'h5C);
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
    rd(3'd5, d); chk("R6 collision dr kept", d, lsta(1, 1));
    rd(3'd0, d); chk("R6 collision new byte", d, 8'hC3);
    rd(3'd5, d); chk("R6 cleared after", d, lsta(0, 1));

    // R8 transmit path
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = 8'(i * 13 + 7);
      wr(3'd0, b);
      chk("R8 tx_load pulse", tx_load, 1);
      chk("R8 tx_byte", tx_byte, b);
      rd(3'd5, d); chk("R8 thre cleared", d, lsta(0, 0));
      chk("R8 tx_load one cycle", tx_load, 0);
      @(negedge clk); tx_taken = 1;
      @(negedge clk); tx_taken = 0;
      rd(3'd5, d); chk("R8 thre set by taken", d, lsta(0, 1));
    end
    // R8 write wins over same-cycle taken
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 8'hE1; tx_taken = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tx_taken = 0;
    rd(3'd5, d); chk("R8 write beats taken", d, lsta(0, 0));
    @(negedge clk); tx_taken = 1;
    @(negedge clk); tx_taken = 0;

    // R9 unused offsets and ignored writes
    wr(3'd3, 8'h1B); wr(3'd1, 8'h05);
    for (int k = 0; k < 5; k++) begin
      logic [2:0] a;
      a = (k == 0) ? 3'd2 : (k == 1) ? 3'd4 : (k == 2) ? 3'd5 : (k == 3) ? 3'd6 : 3'd7;
      wr(a, 8'hFF);
      chk("R9 no tx_load", tx_load, 0);
      rd(3'd3, d); chk("R9 lctl kept", d, 8'h1B);
      rd(3'd1, d); chk("R9 ien kept", d, 8'h05);
      rd(3'd5, d); chk("R9 lsta kept", d, lsta(0, 1));
    end
    rd(3'd4, d); chk("R9 ofs4 zero", d, 8'h00);
    rd(3'd6, d); chk("R9 ofs6 zero", d, 8'h00);
    rd(3'd7, d); chk("R9 ofs7 zero", d, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule